// File: doc/BRIEF.md
# Control Register Write Unit

This block holds the four architectural control words of a processor core: the main mode word, the translation base word, the extension enable word and the extended feature word. It also holds the hidden mode flags that the rest of the pipeline derives from them. Software writes reach it through a single write port. The port has a strobe, a register select and a data word. The block filters each write against the core's capability inputs and may veto it when a long-mode transition is not legal. It then stores the result and raises a one-cycle translation-flush pulse when the write changed a bit that matters to address translation.

The hidden flags are a compact mode vector. It covers protected mode, forced segment-base addition, the three floating-point trap copies, long mode active, 64-bit code segment, the three filtered extension flags, wide-vector enable, bounds-check enable and bounds-preserve. The flush pulse tells the translation cache that it must drop its contents. The cache itself, fault raising and the program counter live elsewhere.

Top module: `ctl_reg_unit`

## Requirements
- R1: Reset values: main word 0x00000010, base, extension and feature words 0, mode flag bit 1 (segment-base add) set and every other mode flag bit 0, flush low.
- R2: A write is applied on the clock edge after the strobe to the one word picked by the 2-bit select (0 main, 1 base, 2 extension, 3 feature). Flush is high only in the cycle after a write that calls for it.
- R3: Main word bit 4 always reads 1, whatever was written.
- R4: A main-word write pulses flush exactly when bit 31 (paging), bit 16 (write protect) or bit 0 (protection) differs between the stored and written value. This holds even when the write is vetoed under R5.
- R5: A main-word write that sets bit 31 from 0 while feature bit 8 is set enters long mode: feature bit 10 and mode flag 5 become 1. If extension bit 5 is 0 at that moment, the write is discarded and the main word, feature word and mode flags stay as they were.
- R6: A main-word write that clears bit 31 from 1 while feature bit 10 is set clears feature bit 10, mode flag 5 and mode flag 6.
- R7: Mode flag 0 equals main bit 0. Mode flag 1 is set by any accepted main write with bit 0 at 0 and is never cleared. Mode flags 2, 3, 4 copy main bits 1, 2, 3.
- R8: A base-word write always stores the data and pulses flush only when main bit 31 is 1.
- R9: An extension-word write pulses flush when any of extension bits 4, 5, 7, 12, 20, 21 toggles.
- R10: On an extension write, capability bits 0..4 gate extension bits 9, 21, 11, 22, 24 in that order; a bit whose capability is 0 is stored as 0. Mode flags 7, 8, 9 follow stored extension bits 9, 21, 11.
- R11: Every cycle the block registers three flags from the next extension word and the current inputs. Flag 10 is extension bit 18 AND state-mask bits 1 and 2. Flag 11 is extension bit 18 AND state-mask bit 4 AND config bit 0. Flag 12 is config bit 1. The config is the user config when the privilege level is 3 and the supervisor config otherwise.
- R12: A feature-word write stores the data unchanged and sets mode flag 5 to written bit 10.
- R13: A code64 set strobe sets mode flag 6 on the next edge, but a long-mode exit (R6) in the same cycle wins and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target word select |
| wr_data | input | XLEN | Write data |
| code64_set | input | 1 | Marks a 64-bit code segment as loaded |
| cap_mask | input | 5 | Capability bits gating extension bits |
| state_mask | input | 8 | Enabled processor state components |
| priv_lvl | input | 2 | Current privilege level |
| bnd_user_cfg | input | 2 | User bounds config (bit 0 enable, bit 1 preserve) |
| bnd_sup_cfg | input | 2 | Supervisor bounds config (bit 0 enable, bit 1 preserve) |
| main_q | output | XLEN | Stored main mode word |
| base_q | output | XLEN | Stored translation base word |
| ext_q | output | XLEN | Stored extension enable word |
| feat_q | output | XLEN | Stored extended feature word |
| mode_flags | output | 13 | Hidden mode flags |
| flush | output | 1 | One-cycle translation flush request |

## Verification
The bench builds the block with its default XLEN of 32. At that width every named bit position lies in range, and random data reaches the paging, write-protect and protection bits and the long-mode transitions. Directed steps first walk long-mode entry, exit, the PAE-less veto with its flush, capability gating and privilege-dependent bounds config. A random phase then mixes writes with changing capability, state-mask and privilege inputs, so that vetoes and same-cycle code64 sets meet exits.

// File: rtl/crw_pkg.sv
package crw_pkg;
    // main word bit positions
    localparam int B_PE = 0;
    localparam int B_MP = 1;
    localparam int B_EM = 2;
    localparam int B_TS = 3;
    localparam int B_ET = 4;
    localparam int B_WP = 16;
    localparam int B_PG = 31;
    // extension word bit positions
    localparam int E_PSE   = 4;
    localparam int E_PAE   = 5;
    localparam int E_PGE   = 7;
    localparam int E_FXSR  = 9;
    localparam int E_UMIP  = 11;
    localparam int E_LA57  = 12;
    localparam int E_XSAVE = 18;
    localparam int E_SMEP  = 20;
    localparam int E_SMAP  = 21;
    localparam int E_PKE   = 22;
    localparam int E_PKS   = 24;
    // feature word bit positions
    localparam int F_LME = 8;
    localparam int F_LMA = 10;
    // mode flag positions
    localparam int M_PROT   = 0;
    localparam int M_ADDSEG = 1;
    localparam int M_MP     = 2;
    localparam int M_EM     = 3;
    localparam int M_TS     = 4;
    localparam int M_LONG   = 5;
    localparam int M_CODE64 = 6;
    localparam int M_FXSR   = 7;
    localparam int M_SMAP   = 8;
    localparam int M_UMIP   = 9;
    localparam int M_VEC    = 10;
    localparam int M_BND    = 11;
    localparam int M_KEEP   = 12;
    localparam int MODE_W   = 13;
    // capability, state-mask and config widths / positions
    localparam int CAP_W    = 5;
    localparam int STATE_W  = 8;
    localparam int S_SSE    = 1;
    localparam int S_YMM    = 2;
    localparam int S_BNDCSR = 4;
    localparam int CFG_W    = 2;
    localparam int PRIV_W   = 2;
    localparam int SEL_W    = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_MAIN = 2'd0,
        SEL_BASE = 2'd1,
        SEL_EXT  = 2'd2,
        SEL_FEAT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/crw_main_path.sv
module crw_main_path
    import crw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   old_main,
    input  logic [XLEN-1:0]   wr_val,
    input  logic [XLEN-1:0]   ext_cur,
    input  logic [XLEN-1:0]   feat_cur,
    input  logic [MODE_W-1:0] mode_cur,
    output logic [XLEN-1:0]   main_nx,
    output logic [XLEN-1:0]   feat_nx,
    output logic [MODE_W-1:0] mode_nx,
    output logic              flush_req
);
    logic entering;
    logic leaving;
    logic veto;

    always_comb begin
        flush_req = (old_main[B_PG] ^ wr_val[B_PG]) |
                    (old_main[B_WP] ^ wr_val[B_WP]) |
                    (old_main[B_PE] ^ wr_val[B_PE]);
        entering  = !old_main[B_PG] && wr_val[B_PG] && feat_cur[F_LME];
        leaving   = old_main[B_PG] && !wr_val[B_PG] && feat_cur[F_LMA];
        veto      = entering && !ext_cur[E_PAE];

        main_nx = old_main;
        feat_nx = feat_cur;
        mode_nx = mode_cur;
        if (!veto) begin
            if (entering) begin
                feat_nx[F_LMA]  = 1'b1;
                mode_nx[M_LONG] = 1'b1;
            end else if (leaving) begin
                feat_nx[F_LMA]    = 1'b0;
                mode_nx[M_LONG]   = 1'b0;
                mode_nx[M_CODE64] = 1'b0;
            end
            main_nx       = wr_val;
            main_nx[B_ET] = 1'b1;
            mode_nx[M_PROT] = wr_val[B_PE];
            if (!wr_val[B_PE]) begin
                mode_nx[M_ADDSEG] = 1'b1;
            end
            mode_nx[M_MP] = wr_val[B_MP];
            mode_nx[M_EM] = wr_val[B_EM];
            mode_nx[M_TS] = wr_val[B_TS];
        end
    end
endmodule

// File: rtl/crw_ext_filter.sv
module crw_ext_filter
    import crw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  old_ext,
    input  logic [XLEN-1:0]  wr_val,
    input  logic [CAP_W-1:0] cap,
    output logic [XLEN-1:0]  ext_nx,
    output logic             flush_req
);
    localparam int GATE_POS [CAP_W] = '{E_FXSR, E_SMAP, E_UMIP, E_PKE, E_PKS};

    logic [XLEN-1:0] toggle_m;

    always_comb begin
        toggle_m         = '0;
        toggle_m[E_PSE]  = 1'b1;
        toggle_m[E_PAE]  = 1'b1;
        toggle_m[E_PGE]  = 1'b1;
        toggle_m[E_LA57] = 1'b1;
        toggle_m[E_SMEP] = 1'b1;
        toggle_m[E_SMAP] = 1'b1;
        flush_req = |((old_ext ^ wr_val) & toggle_m);

        ext_nx = wr_val;
        for (int k = 0; k < CAP_W; k++) begin
            if (!cap[k]) begin
                ext_nx[GATE_POS[k]] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/crw_flag_calc.sv
module crw_flag_calc
    import crw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]    ext_val,
    input  logic [STATE_W-1:0] state_mask,
    input  logic [PRIV_W-1:0]  priv_lvl,
    input  logic [CFG_W-1:0]   user_cfg,
    input  logic [CFG_W-1:0]   sup_cfg,
    output logic               vec_en,
    output logic               bnd_en,
    output logic               bnd_keep
);
    localparam logic [PRIV_W-1:0] USER_LVL = '1;

    logic [CFG_W-1:0] cfg;

    always_comb begin
        cfg      = (priv_lvl == USER_LVL) ? user_cfg : sup_cfg;
        vec_en   = ext_val[E_XSAVE] && state_mask[S_SSE] && state_mask[S_YMM];
        bnd_en   = ext_val[E_XSAVE] && state_mask[S_BNDCSR] && cfg[0];
        bnd_keep = cfg[1];
    end
endmodule

// File: rtl/ctl_reg_unit.sv
module ctl_reg_unit
    import crw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [XLEN-1:0]    wr_data,
    input  logic               code64_set,
    input  logic [CAP_W-1:0]   cap_mask,
    input  logic [STATE_W-1:0] state_mask,
    input  logic [PRIV_W-1:0]  priv_lvl,
    input  logic [CFG_W-1:0]   bnd_user_cfg,
    input  logic [CFG_W-1:0]   bnd_sup_cfg,
    output logic [XLEN-1:0]    main_q,
    output logic [XLEN-1:0]    base_q,
    output logic [XLEN-1:0]    ext_q,
    output logic [XLEN-1:0]    feat_q,
    output logic [MODE_W-1:0]  mode_flags,
    output logic               flush
);
    typedef struct packed {
        logic [XLEN-1:0]   main;
        logic [XLEN-1:0]   base;
        logic [XLEN-1:0]   ext;
        logic [XLEN-1:0]   feat;
        logic [MODE_W-1:0] mode;
        logic              flush;
    } crw_state_t;

    crw_state_t st_d, st_q;
    reg_sel_e   sel;

    logic [MODE_W-1:0] mode_pre;
    logic [XLEN-1:0]   mp_main, mp_feat, ef_ext, ext_next;
    logic [MODE_W-1:0] mp_mode;
    logic              mp_flush, ef_flush;
    logic              fc_vec, fc_bnd, fc_keep;

    assign sel = reg_sel_e'(wr_sel);

    always_comb begin
        mode_pre = st_q.mode;
        if (code64_set) begin
            mode_pre[M_CODE64] = 1'b1;
        end
    end

    assign ext_next = (wr_en && sel == SEL_EXT) ? ef_ext : st_q.ext;

    crw_main_path #(.XLEN(XLEN)) i_main_path (
        .old_main  (st_q.main),
        .wr_val    (wr_data),
        .ext_cur   (st_q.ext),
        .feat_cur  (st_q.feat),
        .mode_cur  (mode_pre),
        .main_nx   (mp_main),
        .feat_nx   (mp_feat),
        .mode_nx   (mp_mode),
        .flush_req (mp_flush)
    );

    crw_ext_filter #(.XLEN(XLEN)) i_ext_filter (
        .old_ext   (st_q.ext),
        .wr_val    (wr_data),
        .cap       (cap_mask),
        .ext_nx    (ef_ext),
        .flush_req (ef_flush)
    );

    crw_flag_calc #(.XLEN(XLEN)) i_flag_calc (
        .ext_val    (ext_next),
        .state_mask (state_mask),
        .priv_lvl   (priv_lvl),
        .user_cfg   (bnd_user_cfg),
        .sup_cfg    (bnd_sup_cfg),
        .vec_en     (fc_vec),
        .bnd_en     (fc_bnd),
        .bnd_keep   (fc_keep)
    );

    always_comb begin
        st_d       = st_q;
        st_d.mode  = mode_pre;
        st_d.flush = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_MAIN: begin
                    st_d.main  = mp_main;
                    st_d.feat  = mp_feat;
                    st_d.mode  = mp_mode;
                    st_d.flush = mp_flush;
                end
                SEL_BASE: begin
                    st_d.base  = wr_data;
                    st_d.flush = st_q.main[B_PG];
                end
                SEL_EXT: begin
                    st_d.ext   = ef_ext;
                    st_d.flush = ef_flush;
                end
                SEL_FEAT: begin
                    st_d.feat         = wr_data;
                    st_d.mode[M_LONG] = wr_data[F_LMA];
                end
            endcase
        end
        st_d.mode[M_FXSR] = ext_next[E_FXSR];
        st_d.mode[M_SMAP] = ext_next[E_SMAP];
        st_d.mode[M_UMIP] = ext_next[E_UMIP];
        st_d.mode[M_VEC]  = fc_vec;
        st_d.mode[M_BND]  = fc_bnd;
        st_d.mode[M_KEEP] = fc_keep;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q              <= '0;
            st_q.main[B_ET]   <= 1'b1;
            st_q.mode[M_ADDSEG] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign main_q     = st_q.main;
    assign base_q     = st_q.base;
    assign ext_q      = st_q.ext;
    assign feat_q     = st_q.feat;
    assign mode_flags = st_q.mode;
    assign flush      = st_q.flush;
endmodule

// File: rtl/ctl_reg_unit_chk.sv
module ctl_reg_unit_chk
    import crw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [XLEN-1:0]   wr_data,
    input logic              code64_set,
    input logic [XLEN-1:0]   main_q,
    input logic [XLEN-1:0]   base_q,
    input logic [XLEN-1:0]   ext_q,
    input logic [MODE_W-1:0] mode_flags,
    input logic              flush
);
    logic main_wr, base_wr, main_quiet;
    assign main_wr    = wr_en && wr_sel == SEL_MAIN;
    assign base_wr    = wr_en && wr_sel == SEL_BASE;
    assign main_quiet = (main_q[B_PG] == wr_data[B_PG]) &&
                        (main_q[B_WP] == wr_data[B_WP]) &&
                        (main_q[B_PE] == wr_data[B_PE]);

    // R3
    et_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_q[B_ET]);

    // R2
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(wr_en));

    // R4
    main_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_wr && main_quiet |=> !flush);

    // R8
    base_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> base_q == $past(wr_data));

    // R8
    base_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> flush == $past(main_q[B_PG]));

    // R7
    prot_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_flags[M_PROT] == main_q[B_PE]);

    // R13
    code64_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code64_set && !main_wr |=> mode_flags[M_CODE64]);

    // R11
    vec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_flags[M_VEC] |-> ext_q[E_XSAVE]);
endmodule

bind ctl_reg_unit ctl_reg_unit_chk #(.XLEN(XLEN)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .code64_set (code64_set),
    .main_q     (main_q),
    .base_q     (base_q),
    .ext_q      (ext_q),
    .mode_flags (mode_flags),
    .flush      (flush)
);

// File: tb/test_ctl_reg_unit.sv
module test_ctl_reg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        code64_set = 1'b0;
    logic [4:0]  cap_mask = 5'h1f;
    logic [7:0]  state_mask = 8'h00;
    logic [1:0]  priv_lvl = 2'd0;
    logic [1:0]  bnd_user_cfg = 2'd0;
    logic [1:0]  bnd_sup_cfg = 2'd0;
    logic [31:0] main_q, base_q, ext_q, feat_q;
    logic [12:0] mode_flags;
    logic        flush;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] r_main, r_base, r_ext, r_feat;
    logic [12:0] r_mode;
    logic        r_flush;

    always #5ns clk = ~clk;

    ctl_reg_unit i_ctl_reg_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .code64_set(code64_set), .cap_mask(cap_mask),
        .state_mask(state_mask), .priv_lvl(priv_lvl),
        .bnd_user_cfg(bnd_user_cfg), .bnd_sup_cfg(bnd_sup_cfg),
        .main_q(main_q), .base_q(base_q), .ext_q(ext_q), .feat_q(feat_q),
        .mode_flags(mode_flags), .flush(flush)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            r_main = 32'h10; r_base = 0; r_ext = 0; r_feat = 0;
            r_mode = 13'h002; r_flush = 0;
        end else begin
            logic [1:0] cfg;
            r_flush = 0;
            if (code64_set) r_mode[6] = 1;
            if (wr_en) begin
                if (wr_sel == 0) begin
                    r_flush = ((r_main ^ wr_data) & 32'h8001_0001) != 0;
                    if (!r_main[31] && wr_data[31] && r_feat[8] && !r_ext[5]) begin
                        // vetoed: nothing stored
                    end else begin
                        if (!r_main[31] && wr_data[31] && r_feat[8]) begin
                            r_feat[10] = 1; r_mode[5] = 1;
                        end else if (r_main[31] && !wr_data[31] && r_feat[10]) begin
                            r_feat[10] = 0; r_mode[5] = 0; r_mode[6] = 0;
                        end
                        r_main = wr_data | 32'h10;
                        r_mode[0] = wr_data[0];
                        if (wr_data[0] == 0) r_mode[1] = 1;
                        r_mode[4:2] = wr_data[3:1];
                    end
                end else if (wr_sel == 1) begin
                    r_base = wr_data;
                    r_flush = r_main[31];
                end else if (wr_sel == 2) begin
                    r_flush = ((r_ext ^ wr_data) & 32'h0030_10B0) != 0;
                    r_ext = wr_data;
                    if (!cap_mask[0]) r_ext[9] = 0;
                    if (!cap_mask[1]) r_ext[21] = 0;
                    if (!cap_mask[2]) r_ext[11] = 0;
                    if (!cap_mask[3]) r_ext[22] = 0;
                    if (!cap_mask[4]) r_ext[24] = 0;
                end else begin
                    r_feat = wr_data;
                    r_mode[5] = wr_data[10];
                end
            end
            r_mode[7] = r_ext[9];
            r_mode[8] = r_ext[21];
            r_mode[9] = r_ext[11];
            cfg = (priv_lvl == 3) ? bnd_user_cfg : bnd_sup_cfg;
            r_mode[10] = r_ext[18] & state_mask[1] & state_mask[2];
            r_mode[11] = r_ext[18] & state_mask[4] & cfg[0];
            r_mode[12] = cfg[1];
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 R4 R5 main word", main_q, r_main);
            chk("R8 base word", base_q, r_base);
            chk("R10 extension word", ext_q, r_ext);
            chk("R5 R6 R12 feature word", feat_q, r_feat);
            chk("R7 R11 R13 mode flags", {19'd0, mode_flags}, {19'd0, r_mode});
            chk("R2 R9 flush", {31'd0, flush}, {31'd0, r_flush});
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        #1ns;
    endtask

    initial begin
        #2ms;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1ns;
        // R1 reset state
        chk("R1 main reset", main_q, 32'h10);
        chk("R1 flags reset", {19'd0, mode_flags}, 32'h2);
        chk("R1 flush reset", {31'd0, flush}, 0);

        wr(0, 32'h1);             // protection on: flush
        chk("R4 flush on bit0 change", {31'd0, flush}, 1);
        chk("R7 prot flag", {31'd0, mode_flags[0]}, 1);
        wr(0, 32'hF);             // only trap bits change
        chk("R4 no flush", {31'd0, flush}, 0);
        chk("R7 trap copies", {29'd0, mode_flags[4:2]}, 7);
        chk("R3 bit4 set", {31'd0, main_q[4]}, 1);
        wr(1, 32'hABCD_E000);     // paging off: no flush
        chk("R8 base no flush", {31'd0, flush}, 0);
        chk("R8 base stored", base_q, 32'hABCD_E000);
        wr(2, 32'h20);            // PAE toggles
        chk("R9 ext flush", {31'd0, flush}, 1);
        wr(3, 32'h100);           // long enable
        chk("R12 feature stored", feat_q, 32'h100);
        wr(0, 32'h8000_0001);     // enter long mode
        chk("R5 long active", {31'd0, feat_q[10]}, 1);
        chk("R5 long flag", {31'd0, mode_flags[5]}, 1);
        wr(1, 32'h1000);
        chk("R8 base flush with paging", {31'd0, flush}, 1);
        @(negedge clk); code64_set = 1; @(negedge clk); code64_set = 0; #1ns;
        chk("R13 code64 set", {31'd0, mode_flags[6]}, 1);
        // same-cycle code64 set and long exit: exit wins
        @(negedge clk);
        wr_en = 1; wr_sel = 0; wr_data = 32'h1; code64_set = 1;
        @(negedge clk); wr_en = 0; code64_set = 0; #1ns;
        chk("R6 long cleared", {31'd0, feat_q[10]}, 0);
        chk("R13 exit wins", {31'd0, mode_flags[6]}, 0);
        // veto: no PAE
        wr(2, 32'h0);
        wr(0, 32'h8000_0003);
        chk("R5 veto keeps main", main_q, 32'h11);
        chk("R4 veto still flushes", {31'd0, flush}, 1);
        // capability gating
        cap_mask = 5'h00;
        wr(2, 32'h01FF_FFFF);
        chk("R10 gated", ext_q & 32'h01600A00, 0);
        cap_mask = 5'h05;
        wr(2, 32'h0120_0A00);
        chk("R10 partial", ext_q, 32'h0000_0A00);
        chk("R10 flags", {29'd0, mode_flags[9:7]}, 3'b101);
        // wide vector and bounds flags
        cap_mask = 5'h1f;
        state_mask = 8'h16; bnd_user_cfg = 2'b11; bnd_sup_cfg = 2'b00; priv_lvl = 3;
        wr(2, 32'h0004_0000);
        @(negedge clk); #1ns;
        chk("R11 vector en", {31'd0, mode_flags[10]}, 1);
        chk("R11 bounds user", {30'd0, mode_flags[12:11]}, 3);
        priv_lvl = 0;
        @(negedge clk); @(negedge clk); #1ns;
        chk("R11 bounds supervisor", {30'd0, mode_flags[12:11]}, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            wr_en = ($urandom % 3) != 0;
            wr_sel = 2'($urandom);
            wr_data = $urandom & (($urandom % 2) ? 32'h8001_010F : 32'hFFFF_FFFF);
            code64_set = ($urandom % 6) == 0;
            cap_mask = 5'($urandom);
            state_mask = 8'($urandom);
            priv_lvl = 2'($urandom);
            bnd_user_cfg = 2'($urandom);
            bnd_sup_cfg = 2'($urandom);
        end
        @(negedge clk); wr_en = 0; code64_set = 0;
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule